// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Controller

This block sits in the program-control path of a small signal-processing core and runs hardware loops with no branch instruction and no lost cycle per pass. A loop-start strobe gives an iteration count and the address of the last instruction of the body. The body is taken to begin at the instruction after the one fetched in the cycle of the strobe. On every valid fetch the block compares the fetch address with the end address of the innermost live loop. In that same cycle it either steers fetch back to the body start or lets fetch fall through.

Two loops may be live at once, one inside the other. Each live loop keeps its own end address and remaining count in its own register pair. Body start addresses sit on a dedicated two-entry stack. While an interrupt handler runs, the loop machinery is frozen, so a loop that was cut off resumes with the same count once the handler returns.

Top module: `znl_loop_ctrl`

## Requirements
- R1: A loop-start strobe with a nonzero count, taken while fewer than two loops are live, makes a new innermost loop. Its start is fetch_pc+1 from the strobe cycle, and it takes the given end address and count. loop_depth rises by one on the next clock, and redirect stays low in the strobe cycle.
- R2: In a cycle with fetch_valid high, fetch_pc equal to the innermost end address and a remaining count above 1, redirect is high in that same cycle and redirect_pc is the innermost start. One iteration is then used up. With fetch_valid low, or with no live loop and no strobe, redirect stays low.
- R3: The count N gives exactly N passes. On the fetch of the end address with one pass left, redirect stays low, the loop is removed, and loop_depth falls by one on the next clock.
- R4: When an inner loop is removed, the outer loop's start, end and remaining count take over the end-address match unchanged.
- R5: loop_done is high for exactly the one cycle after a fetch that finishes one or two loops, and low otherwise.
- R6: A nonzero-count strobe while two loops are live is ignored: depth, the live loops and redirect are unchanged. loop_overflow goes high on the next clock and stays high until reset.
- R7: A strobe with count 0 makes no loop at any depth and raises no overflow. In that same cycle, redirect is high with redirect_pc equal to the given end address plus 1.
- R8: A quiet window begins in the cycle where irq_enter is high and lasts through the cycle where irq_exit is high. In that window, redirect is low, no count changes and strobes are ignored. After the window, the interrupted loop goes on with the count it had.
- R9: Both loops may end on the same address. When the inner loop's last pass reaches it, the outer loop is judged in that same fetch. If the outer loop has passes left, fetch is redirected to the outer start. If it is on its last pass, both loops are removed together.
- R10: Reset clears loop_depth, loop_done and loop_overflow to 0. With no inputs active, redirect is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | fetch_pc holds a real fetch this cycle |
| fetch_pc | input | 24 | Address being fetched |
| loop_start | input | 1 | Loop-start strobe |
| loop_count | input | 13 | Iteration count for the strobe |
| loop_end | input | 24 | Last body address for the strobe |
| irq_enter | input | 1 | Pulse: an interrupt handler is entered |
| irq_exit | input | 1 | Pulse: the handler returns |
| redirect | output | 1 | Next-PC select: take redirect_pc instead of the sequential address |
| redirect_pc | output | 24 | Target when redirect is high |
| loop_depth | output | 2 | Number of live loops (0, 1 or 2) |
| loop_done | output | 1 | One-cycle pulse after a loop finishes |
| loop_overflow | output | 1 | Sticky: a third loop was requested |

## Verification
The bench targets the cycle in which a loop's last pass ends. A design that decrements before comparing would run one pass too few, and one that redirects on a count of 1 would run one pass too many. It drives both loops onto one shared end address. A controller that judges only the innermost loop would then skip straight past the outer loop's loop-back. It takes an interrupt on the very fetch of an end address, with a handler that fetches that same address and issues strobes. A controller that is not frozen would consume an iteration or build a stray loop, and the resumed loop would come up one pass short. It also sends a third start and zero-count starts at full depth. A design that lets these through would corrupt the inner loop's start entry or raise a false overflow.

// File: rtl/znl_pkg.sv
package znl_pkg;
  localparam int ZNL_ADDR_W = 24;
  localparam int ZNL_CNT_W  = 13;
  localparam int ZNL_NEST   = 2;

  // how many live loops a single fetch removes
  typedef enum logic [1:0] {
    UNWIND_NONE = 2'd0,
    UNWIND_ONE  = 2'd1,
    UNWIND_TWO  = 2'd2
  } unwind_e;
endpackage

// File: rtl/znl_start_stack.sv
module znl_start_stack #(
  parameter int NEST = 2,
  parameter int AW   = 24,
  localparam int DW  = $clog2(NEST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] depth,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr,
  output logic [AW-1:0] nxt_addr
);
  logic [AW-1:0] slot_q [NEST];

  for (genvar g = 0; g < NEST; g++) begin : g_slot
    logic slot_we;
    assign slot_we = push && (depth == DW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[g] <= '0;
      else if (slot_we) slot_q[g] <= push_addr;
    end
  end

  // innermost entry sits at depth-1, the enclosing one at depth-2
  always_comb begin
    top_addr = '0;
    nxt_addr = '0;
    for (int i = 0; i < NEST; i++) begin
      if (depth == DW'(i + 1)) top_addr = slot_q[i];
      if (depth == DW'(i + 2)) nxt_addr = slot_q[i];
    end
  end
endmodule

// File: rtl/znl_loop_bank.sv
module znl_loop_bank #(
  parameter int NEST = 2,
  parameter int AW   = 24,
  parameter int CW   = 13,
  localparam int DW  = $clog2(NEST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] depth,
  input  logic          push,
  input  logic [AW-1:0] push_end,
  input  logic [CW-1:0] push_cnt,
  input  logic          dec_en,
  input  logic [DW-1:0] dec_idx,
  output logic [AW-1:0] top_end,
  output logic [CW-1:0] top_cnt,
  output logic [AW-1:0] nxt_end,
  output logic [CW-1:0] nxt_cnt
);
  function automatic logic [CW-1:0] one_less(input logic [CW-1:0] c);
    return c - 1'b1;
  endfunction

  logic [AW-1:0] end_q [NEST];
  logic [CW-1:0] cnt_q [NEST];

  for (genvar g = 0; g < NEST; g++) begin : g_level
    logic load_hit;
    logic dec_hit;
    assign load_hit = push && (depth == DW'(g));
    assign dec_hit  = dec_en && (dec_idx == DW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        end_q[g] <= '0;
        cnt_q[g] <= '0;
      end else if (load_hit) begin
        end_q[g] <= push_end;
        cnt_q[g] <= push_cnt;
      end else if (dec_hit) begin
        cnt_q[g] <= one_less(cnt_q[g]);
      end
    end

    // a pass is only consumed while another one remains after it
    AST_DEC_ABOVE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit |-> cnt_q[g] > CW'(1)); // R3
  end

  always_comb begin
    top_end = '0;
    top_cnt = '0;
    nxt_end = '0;
    nxt_cnt = '0;
    for (int i = 0; i < NEST; i++) begin
      if (depth == DW'(i + 1)) begin
        top_end = end_q[i];
        top_cnt = cnt_q[i];
      end
      if (depth == DW'(i + 2)) begin
        nxt_end = end_q[i];
        nxt_cnt = cnt_q[i];
      end
    end
  end
endmodule

// File: rtl/znl_decide.sv
module znl_decide import znl_pkg::*; #(
  parameter int NEST = 2,
  parameter int AW   = 24,
  parameter int CW   = 13,
  localparam int DW  = $clog2(NEST + 1)
) (
  input  logic [DW-1:0] depth,
  input  logic          suppress,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          start_req,
  input  logic [CW-1:0] req_cnt,
  input  logic [AW-1:0] req_end,
  input  logic [AW-1:0] top_start,
  input  logic [AW-1:0] top_end,
  input  logic [CW-1:0] top_cnt,
  input  logic [AW-1:0] nxt_start,
  input  logic [AW-1:0] nxt_end,
  input  logic [CW-1:0] nxt_cnt,
  output logic          redirect,
  output logic [AW-1:0] target,
  output logic          push,
  output logic [AW-1:0] push_start,
  output unwind_e       unwind,
  output logic          dec_en,
  output logic          dec_outer,
  output logic          ovf_set,
  output logic          done_evt
);
  function automatic logic last_pass(input logic [CW-1:0] c);
    return c <= CW'(1);
  endfunction

  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  logic full;
  logic top_hit;
  logic nxt_hit;

  assign full       = (depth == DW'(NEST));
  assign top_hit    = fetch_valid && (depth != '0) && (fetch_pc == top_end);
  assign nxt_hit    = (depth > DW'(1)) && (fetch_pc == nxt_end);
  assign push_start = addr_after(fetch_pc);

  always_comb begin
    redirect  = 1'b0;
    target    = '0;
    push      = 1'b0;
    unwind    = UNWIND_NONE;
    dec_en    = 1'b0;
    dec_outer = 1'b0;
    ovf_set   = 1'b0;
    done_evt  = 1'b0;
    if (!suppress) begin
      if (start_req) begin
        if (req_cnt == '0) begin
          redirect = 1'b1;
          target   = addr_after(req_end);
        end else if (full) begin
          ovf_set = 1'b1;
        end else begin
          push = 1'b1;
        end
      end else if (top_hit) begin
        if (!last_pass(top_cnt)) begin
          redirect = 1'b1;
          target   = top_start;
          dec_en   = 1'b1;
        end else begin
          done_evt = 1'b1;
          unwind   = UNWIND_ONE;
          if (nxt_hit) begin
            if (!last_pass(nxt_cnt)) begin
              redirect  = 1'b1;
              target    = nxt_start;
              dec_en    = 1'b1;
              dec_outer = 1'b1;
            end else begin
              unwind = UNWIND_TWO;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/znl_loop_ctrl.sv
module znl_loop_ctrl import znl_pkg::*; #(
  parameter int NEST = ZNL_NEST,
  parameter int AW   = ZNL_ADDR_W,
  parameter int CW   = ZNL_CNT_W,
  localparam int DW  = $clog2(NEST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          loop_start,
  input  logic [CW-1:0] loop_count,
  input  logic [AW-1:0] loop_end,
  input  logic          irq_enter,
  input  logic          irq_exit,
  output logic          redirect,
  output logic [AW-1:0] redirect_pc,
  output logic [DW-1:0] loop_depth,
  output logic          loop_done,
  output logic          loop_overflow
);
  logic [DW-1:0] depth_q;
  logic          isr_q;
  logic          done_q;
  logic          ovf_q;
  logic          suppress;

  logic [AW-1:0] top_start, nxt_start, top_end, nxt_end;
  logic [CW-1:0] top_cnt, nxt_cnt;
  logic          push_evt, dec_en, dec_outer, ovf_set, done_evt;
  logic [AW-1:0] push_start;
  logic [DW-1:0] dec_idx;
  unwind_e       unwind;

  assign suppress = isr_q | irq_enter;
  assign dec_idx  = dec_outer ? (depth_q - DW'(2)) : (depth_q - DW'(1));

  znl_start_stack #(.NEST(NEST), .AW(AW)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .depth     (depth_q),
    .push      (push_evt),
    .push_addr (push_start),
    .top_addr  (top_start),
    .nxt_addr  (nxt_start)
  );

  znl_loop_bank #(.NEST(NEST), .AW(AW), .CW(CW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .depth    (depth_q),
    .push     (push_evt),
    .push_end (loop_end),
    .push_cnt (loop_count),
    .dec_en   (dec_en),
    .dec_idx  (dec_idx),
    .top_end  (top_end),
    .top_cnt  (top_cnt),
    .nxt_end  (nxt_end),
    .nxt_cnt  (nxt_cnt)
  );

  znl_decide #(.NEST(NEST), .AW(AW), .CW(CW)) u_decide (
    .depth       (depth_q),
    .suppress    (suppress),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .start_req   (loop_start),
    .req_cnt     (loop_count),
    .req_end     (loop_end),
    .top_start   (top_start),
    .top_end     (top_end),
    .top_cnt     (top_cnt),
    .nxt_start   (nxt_start),
    .nxt_end     (nxt_end),
    .nxt_cnt     (nxt_cnt),
    .redirect    (redirect),
    .target      (redirect_pc),
    .push        (push_evt),
    .push_start  (push_start),
    .unwind      (unwind),
    .dec_en      (dec_en),
    .dec_outer   (dec_outer),
    .ovf_set     (ovf_set),
    .done_evt    (done_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      isr_q   <= 1'b0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (push_evt) depth_q <= depth_q + 1'b1;
      else          depth_q <= depth_q - DW'(unwind);
      if (irq_enter)     isr_q <= 1'b1;
      else if (irq_exit) isr_q <= 1'b0;
      done_q <= done_evt;
      ovf_q  <= ovf_q | ovf_set;
    end
  end

  assign loop_depth    = depth_q;
  assign loop_done     = done_q;
  assign loop_overflow = ovf_q;

  AST_PUSH_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> depth_q == $past(depth_q) + 1'b1); // R1
  AST_IDLE_NO_LOOPBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_q == '0 && !loop_start) |-> !redirect); // R2
  AST_DONE_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |-> depth_q < $past(depth_q)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    loop_overflow |=> loop_overflow); // R6
  AST_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_q == DW'(NEST) && loop_start && loop_count != '0 && !suppress)
      |=> (loop_overflow && depth_q == DW'(NEST))); // R6
  AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_start && loop_count == '0 && !suppress)
      |-> (redirect && redirect_pc == loop_end + 1'b1)); // R7
  AST_ISR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    isr_q |-> !redirect); // R8
  AST_ISR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    isr_q |=> depth_q == $past(depth_q)); // R8
endmodule

// File: tb/znl_loop_ctrl_tb.sv
module znl_loop_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [23:0] fetch_pc = '0;
  logic        loop_start = 1'b0;
  logic [12:0] loop_count = '0;
  logic [23:0] loop_end = '0;
  logic        irq_enter = 1'b0;
  logic        irq_exit = 1'b0;
  logic        redirect;
  logic [23:0] redirect_pc;
  logic [1:0]  loop_depth;
  logic        loop_done;
  logic        loop_overflow;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  znl_loop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .loop_start(loop_start), .loop_count(loop_count), .loop_end(loop_end),
    .irq_enter(irq_enter), .irq_exit(irq_exit), .redirect(redirect),
    .redirect_pc(redirect_pc), .loop_depth(loop_depth), .loop_done(loop_done),
    .loop_overflow(loop_overflow)
  );

  // fields: fv, pc[8], start, cnt[8], end[8], ienter, iexit | redirect, target[8], depth[2], done
  localparam int NV = 30;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1,8'h10,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0},
    {1'b1,8'h11,1'b1,8'd2,8'h18,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0},
    {1'b1,8'h12,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd1,1'b0},
    {1'b1,8'h13,1'b1,8'd2,8'h15,1'b0,1'b0, 1'b0,8'h00,2'd1,1'b0},
    {1'b1,8'h14,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd2,1'b0},
    {1'b1,8'h15,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b1,8'h14,2'd2,1'b0},
    {1'b1,8'h14,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd2,1'b0},
    {1'b1,8'h15,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd2,1'b0},
    {1'b1,8'h16,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd1,1'b1},
    {1'b1,8'h17,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd1,1'b0},
    {1'b1,8'h18,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b1,8'h12,2'd1,1'b0},
    {1'b1,8'h12,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd1,1'b0},
    {1'b1,8'h13,1'b1,8'd2,8'h15,1'b0,1'b0, 1'b0,8'h00,2'd1,1'b0},
    {1'b1,8'h14,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd2,1'b0},
    {1'b1,8'h15,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b1,8'h14,2'd2,1'b0},
    {1'b1,8'h14,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd2,1'b0},
    {1'b1,8'h15,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd2,1'b0},
    {1'b1,8'h16,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd1,1'b1},
    {1'b1,8'h17,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd1,1'b0},
    {1'b1,8'h18,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd1,1'b0},
    {1'b1,8'h19,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b1},
    {1'b1,8'h20,1'b1,8'd3,8'h22,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b0},
    {1'b1,8'h21,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd1,1'b0},
    {1'b0,8'h22,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd1,1'b0},
    {1'b1,8'h22,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b1,8'h21,2'd1,1'b0},
    {1'b1,8'h21,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd1,1'b0},
    {1'b1,8'h22,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b1,8'h21,2'd1,1'b0},
    {1'b1,8'h21,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd1,1'b0},
    {1'b1,8'h22,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd1,1'b0},
    {1'b1,8'h23,1'b0,8'd0,8'h00,1'b0,1'b0, 1'b0,8'h00,2'd0,1'b1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic cyc(input logic fv, input logic [23:0] pc, input logic ls, input logic [12:0] cnt,
                     input logic [23:0] e, input logic ie, input logic ix);
    @(negedge clk);
    fetch_valid = fv; fetch_pc = pc; loop_start = ls; loop_count = cnt;
    loop_end = e; irq_enter = ie; irq_exit = ix;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fetch_valid = 0; fetch_pc = '0; loop_start = 0; loop_count = '0;
    loop_end = '0; irq_enter = 0; irq_exit = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10", "depth", 32'(loop_depth), 0);
    chk("R10", "redirect", 32'(redirect), 0);
    chk("R10", "done", 32'(loop_done), 0);
    chk("R10", "overflow", 32'(loop_overflow), 0);

    // nested loops, re-entry of the inner loop, fetch_valid gating
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      cyc(v[39], 24'(v[38:31]), v[30], 13'(v[29:22]), 24'(v[21:14]), v[13], v[12]);
      chk(v[11] ? "R2" : "R3", $sformatf("vec%0d redirect", i), 32'(redirect), 32'(v[11]));
      if (v[11]) chk("R2", $sformatf("vec%0d target", i), 32'(redirect_pc), 32'(v[10:3]));
      chk("R4", $sformatf("vec%0d depth", i), 32'(loop_depth), 32'(v[2:1]));
      chk("R5", $sformatf("vec%0d done", i), 32'(loop_done), 32'(v[0]));
    end

    // R8: interrupt taken on the fetch of the end address
    do_reset();
    cyc(1, 24'h20, 1, 13'd2, 24'h22, 0, 0);
    chk("R1", "no redirect on start", 32'(redirect), 0);
    cyc(1, 24'h21, 0, 0, 0, 0, 0);
    chk("R1", "depth after start", 32'(loop_depth), 1);
    cyc(1, 24'h22, 0, 0, 0, 1, 0);
    chk("R8", "quiet on enter", 32'(redirect), 0);
    cyc(1, 24'h22, 0, 0, 0, 0, 0);
    chk("R8", "quiet in handler", 32'(redirect), 0);
    cyc(1, 24'h50, 1, 13'd3, 24'h60, 0, 0);
    chk("R8", "start ignored", 32'(redirect), 0);
    cyc(1, 24'h52, 1, 13'd0, 24'h70, 0, 0);
    chk("R8", "depth unchanged", 32'(loop_depth), 1);
    chk("R8", "zero start ignored", 32'(redirect), 0);
    cyc(1, 24'h22, 0, 0, 0, 0, 1);
    chk("R8", "quiet on exit", 32'(redirect), 0);
    cyc(1, 24'h22, 0, 0, 0, 0, 0);
    chk("R8", "resume redirect", 32'(redirect), 1);
    chk("R8", "resume target", 32'(redirect_pc), 32'h21);
    cyc(1, 24'h21, 0, 0, 0, 0, 0);
    cyc(1, 24'h22, 0, 0, 0, 0, 0);
    chk("R8", "count kept: last pass", 32'(redirect), 0);
    cyc(1, 24'h23, 0, 0, 0, 0, 0);
    chk("R8", "loop ended", 32'(loop_depth), 0);

    // R7: zero count at depth 0
    cyc(1, 24'h30, 1, 13'd0, 24'h40, 0, 0);
    chk("R7", "skip redirect", 32'(redirect), 1);
    chk("R7", "skip target", 32'(redirect_pc), 32'h41);
    cyc(1, 24'h41, 0, 0, 0, 0, 0);
    chk("R7", "no loop made", 32'(loop_depth), 0);
    chk("R7", "no overflow", 32'(loop_overflow), 0);

    // R6: third start while full
    do_reset();
    cyc(1, 24'h60, 1, 13'd2, 24'h80, 0, 0);
    cyc(1, 24'h61, 1, 13'd2, 24'h70, 0, 0);
    cyc(1, 24'h62, 0, 0, 0, 0, 0);
    chk("R6", "full depth", 32'(loop_depth), 2);
    cyc(1, 24'h63, 1, 13'd5, 24'h68, 0, 0);
    chk("R6", "third start no redirect", 32'(redirect), 0);
    cyc(1, 24'h64, 0, 0, 0, 0, 0);
    chk("R6", "overflow set", 32'(loop_overflow), 1);
    chk("R6", "depth held", 32'(loop_depth), 2);
    cyc(1, 24'h70, 0, 0, 0, 0, 0);
    chk("R6", "inner start intact", 32'(redirect_pc), 32'h62);
    chk("R6", "inner loops back", 32'(redirect), 1);
    cyc(1, 24'h62, 1, 13'd0, 24'h65, 0, 0);
    chk("R7", "skip at full depth", 32'(redirect_pc), 32'h66);
    cyc(1, 24'h66, 0, 0, 0, 0, 0);
    chk("R7", "depth after skip", 32'(loop_depth), 2);
    chk("R6", "overflow sticky", 32'(loop_overflow), 1);
    do_reset();
    chk("R10", "overflow cleared", 32'(loop_overflow), 0);

    // R9: shared end address
    cyc(1, 24'h00, 1, 13'd2, 24'h05, 0, 0);
    cyc(1, 24'h01, 1, 13'd1, 24'h05, 0, 0);
    cyc(1, 24'h02, 0, 0, 0, 0, 0);
    cyc(1, 24'h05, 0, 0, 0, 0, 0);
    chk("R9", "outer loops back", 32'(redirect), 1);
    chk("R9", "outer target", 32'(redirect_pc), 32'h01);
    cyc(1, 24'h01, 1, 13'd1, 24'h05, 0, 0);
    chk("R9", "one level removed", 32'(loop_depth), 1);
    chk("R5", "done after inner", 32'(loop_done), 1);
    cyc(1, 24'h02, 0, 0, 0, 0, 0);
    cyc(1, 24'h05, 0, 0, 0, 0, 0);
    chk("R9", "both last: fall through", 32'(redirect), 0);
    cyc(1, 24'h06, 0, 0, 0, 0, 0);
    chk("R9", "both removed", 32'(loop_depth), 0);
    chk("R5", "single done pulse", 32'(loop_done), 1);
    cyc(1, 24'h07, 0, 0, 0, 0, 0);
    chk("R5", "done drops", 32'(loop_done), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule